// File: doc/BRIEF.md
# Write Strobe Consistency Checker

This block is the write-side front end of an AXI4 slave. It takes one write address per burst, tracks the byte address of every data beat of an incrementing burst, and checks each beat's byte enables against the lanes that beat is allowed to touch. Beats that pass the check go to a byte-enabled storage port. The lowest asserted enable, not the address, sets the start byte of each storage write.

There are two legal ways to begin a write partway into a bus word. The address may carry the start lane in its low bits. Or the address may be aligned to the transfer size, with the enables of the first beat left low on the bytes below the real start. Both are accepted. A first beat with an enable on a byte below the address offset, or beyond the size window, is a violation. So is any enable outside a later beat's window, and so is a transfer size wider than the bus.

After a violation, the offending beat and every later beat of that burst are dropped. The burst still runs to its last beat and closes with an error response. A one-cycle pulse, with the address of the offending beat, lets a monitor log the event. The address, data and response channels use valid/ready handshakes with back-pressure:
- The block holds `s_awready` low from an accepted address until its response has been taken.
- It holds `s_wready` high only while a burst is open.
- It keeps a response on the channel, unchanged, until the master takes it.

The storage port and the pulse output have no back-pressure. Data widths of 32 and 64 bits are supported.

Top module: `wstrb_guard`

## Requirements
- R1: `s_awready` is high only while no burst is open and no response is pending. It is low from the cycle after an address handshake until the cycle after the response handshake.
- R2: `s_wready` is high from the cycle after an address handshake through the beat accepted with `s_wlast` high, and low otherwise.
- R3: One cycle after an accepted beat that passes the check and has at least one enable set, `mem_we` is high for one cycle. In that cycle `mem_be` equals the beat's `s_wstrb` and `mem_wdata` equals its `s_wdata`. `mem_addr` is the beat's bus-word address with its low log2(DATA_W/8) bits replaced by the index of the lowest set enable bit.
- R4: For the first beat, let o be `s_awaddr` mod (DATA_W/8) and let n be 2^`s_awsize`. The legal lanes run from o up to the last lane of the n-byte window that contains o. An enable on any other lane is a violation. An aligned address whose enables start above lane o passes.
- R5: Beat k>0 has address A_k, where A_k = (A_{k-1} with its low `s_awsize` bits cleared) + 2^`s_awsize` and A_0 is `s_awaddr`. Its legal lanes are the n-byte window holding A_k mod (DATA_W/8), and an enable outside that window is a violation.
- R6: A beat with all enables zero is never a violation and causes no storage write.
- R7: After a violation, neither the offending beat nor any later beat of the burst is written. The response is SLVERR (2'b10). A burst without a violation gets OKAY (2'b00).
- R8: On the first violation of a burst, `viol_pulse` is high for one cycle, one cycle after that beat's handshake, with `viol_addr` = A_k of that beat. Later violations in the same burst give no pulse.
- R9: `s_bvalid` rises one cycle after the handshake of the beat with `s_wlast` high. It stays high with `s_bresp` unchanged until `s_bready` is high at a clock edge.
- R10: An `s_awsize` above log2(DATA_W/8) makes the first beat a violation.
- R11: During and after reset, `s_awready` is 1, and `s_wready`, `s_bvalid`, `mem_we` and `viol_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Byte address of the first beat |
| s_awsize | input | 3 | log2 of bytes per beat |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Byte enables, bit i for byte lane i |
| s_wlast | input | 1 | Last beat of the burst |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | 2'b00 OKAY, 2'b10 SLVERR |
| mem_we | output | 1 | Storage write pulse |
| mem_addr | output | ADDR_W | Byte address of the lowest enabled byte |
| mem_be | output | DATA_W/8 | Storage byte enables |
| mem_wdata | output | DATA_W | Storage write data |
| viol_pulse | output | 1 | One-cycle pulse on the first violation of a burst |
| viol_addr | output | ADDR_W | Address of the offending beat |

## Verification
The lane check itself is combinational, so a beat's verdict costs no cycle before its handshake. The verdict's effects appear one clock after the handshake edge:
- the storage write (`mem_we` and the port's address, enables and data),
- the violation pulse and its address,
- the rise of `s_bvalid` after the last beat.

`s_awready` returns one clock after the response handshake. The bench drives every input on the falling edge and, after each handshake edge, reads the results on the next falling edge. That is exactly the cycle in which the one-cycle pulses are due, and it is reached before the next beat is presented. Each scenario also holds `s_bready` low for a cycle and offers a new address, to see the response held and the address refused.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_RESP = 2'd2
  } wsg_state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef struct packed {
    logic bad;
    logic empty;
  } wsg_verdict_t;

endpackage

// File: rtl/wsg_beat_addr.sv
// Tracks the byte address of the current beat of an incrementing burst.
module wsg_beat_addr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [2:0]        load_size,
  input  logic              advance,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [2:0]        beat_size,
  output logic              first_beat
);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] low_mask;

  assign step     = ADDR_W'(1) << beat_size;
  assign low_mask = step - ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_addr  <= '0;
      beat_size  <= '0;
      first_beat <= 1'b0;
    end else if (load) begin
      beat_addr  <= load_addr;
      beat_size  <= load_size;
      first_beat <= 1'b1;
    end else if (advance) begin
      // next beat starts at the aligned address one transfer further on
      beat_addr  <= (beat_addr & ~low_mask) + step;
      first_beat <= 1'b0;
    end
  end

endmodule

// File: rtl/wsg_lane_check.sv
// Combinational lane window check and lowest-enable encoder.
module wsg_lane_check
  import wsg_pkg::*;
#(
  parameter int STRB_W = 4,
  parameter int OFF_W  = 2
) (
  input  logic [OFF_W-1:0]  lane_off,
  input  logic [2:0]        size,
  input  logic              first_beat,
  input  logic [STRB_W-1:0] strb,
  output wsg_verdict_t      verdict,
  output logic [OFF_W-1:0]  low_lane
);

  logic              oversize;
  logic [OFF_W:0]    nbytes;
  logic [OFF_W:0]    win_base;
  logic [OFF_W:0]    win_top;
  logic [OFF_W:0]    lo_lane;
  logic [STRB_W-1:0] legal;

  assign oversize = size > 3'(OFF_W);
  assign nbytes   = oversize ? (OFF_W+1)'(STRB_W) : ((OFF_W+1)'(1) << size);
  assign win_base = {1'b0, lane_off} & ~(nbytes - (OFF_W+1)'(1));
  assign win_top  = win_base + nbytes - (OFF_W+1)'(1);
  assign lo_lane  = first_beat ? {1'b0, lane_off} : win_base;

  // every lane compares against both window bounds in parallel
  for (genvar i = 0; i < STRB_W; i++) begin : g_lane
    localparam logic [OFF_W:0] LANE = (OFF_W+1)'(i);
    assign legal[i] = (LANE >= lo_lane) && (LANE <= win_top);
  end

  assign verdict.empty = (strb == '0);
  assign verdict.bad   = (|(strb & ~legal)) || (oversize && first_beat);

  always_comb begin
    low_lane = '0;
    for (int i = STRB_W - 1; i >= 0; i--) begin
      if (strb[i]) low_lane = OFF_W'(i);
    end
  end

endmodule

// File: rtl/wsg_ctrl.sv
// Burst sequencing, sticky error and write response.
module wsg_ctrl
  import wsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aw_fire,
  input  logic       w_fire,
  input  logic       w_last,
  input  logic       beat_bad,
  input  logic       b_ready,
  output logic       idle,
  output logic       open_burst,
  output logic       err_seen,
  output logic       b_valid,
  output logic [1:0] b_resp
);

  wsg_state_e state;
  logic       err_next;

  assign idle       = (state == ST_IDLE);
  assign open_burst = (state == ST_DATA);
  assign b_valid    = (state == ST_RESP);
  assign err_next   = err_seen | beat_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      err_seen <= 1'b0;
      b_resp   <= RESP_OKAY;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (aw_fire) begin
            state    <= ST_DATA;
            err_seen <= 1'b0;
          end
        end
        ST_DATA: begin
          if (w_fire) begin
            err_seen <= err_next;
            if (w_last) begin
              state  <= ST_RESP;
              b_resp <= err_next ? RESP_SLVERR : RESP_OKAY;
            end
          end
        end
        ST_RESP: begin
          if (b_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wstrb_guard.sv
module wstrb_guard
  import wsg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [2:0]          s_awsize,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wlast,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [1:0]          s_bresp,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                viol_pulse,
  output logic [ADDR_W-1:0]   viol_addr
);

  localparam int STRB_W = DATA_W / 8;
  localparam int OFF_W  = $clog2(STRB_W);

  logic              aw_fire;
  logic              w_fire;
  logic              idle;
  logic              open_burst;
  logic              err_seen;
  logic [ADDR_W-1:0] beat_addr;
  logic [2:0]        beat_size;
  logic              first_beat;
  wsg_verdict_t      verdict;
  logic [OFF_W-1:0]  low_lane;
  logic              do_write;
  logic              new_viol;

  assign s_awready = idle;
  assign s_wready  = open_burst;
  assign aw_fire   = s_awvalid && idle;
  assign w_fire    = s_wvalid && open_burst;

  wsg_beat_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (aw_fire),
    .load_addr  (s_awaddr),
    .load_size  (s_awsize),
    .advance    (w_fire),
    .beat_addr  (beat_addr),
    .beat_size  (beat_size),
    .first_beat (first_beat)
  );

  wsg_lane_check #(.STRB_W(STRB_W), .OFF_W(OFF_W)) u_check (
    .lane_off   (beat_addr[OFF_W-1:0]),
    .size       (beat_size),
    .first_beat (first_beat),
    .strb       (s_wstrb),
    .verdict    (verdict),
    .low_lane   (low_lane)
  );

  wsg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .aw_fire    (aw_fire),
    .w_fire     (w_fire),
    .w_last     (s_wlast),
    .beat_bad   (verdict.bad),
    .b_ready    (s_bready),
    .idle       (idle),
    .open_burst (open_burst),
    .err_seen   (err_seen),
    .b_valid    (s_bvalid),
    .b_resp     (s_bresp)
  );

  assign do_write = w_fire && !verdict.bad && !err_seen && !verdict.empty;
  assign new_viol = w_fire && verdict.bad && !err_seen;

  // registered storage port and monitor pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      viol_pulse <= 1'b0;
      viol_addr  <= '0;
    end else begin
      mem_we     <= do_write;
      viol_pulse <= new_viol;
      if (do_write) begin
        mem_addr  <= {beat_addr[ADDR_W-1:OFF_W], low_lane};
        mem_be    <= s_wstrb;
        mem_wdata <= s_wdata;
      end
      if (new_viol) viol_addr <= beat_addr;
    end
  end

endmodule

// File: rtl/wsg_guard_sva.sv
module wsg_guard_sva #(
  parameter int STRB_W = 4,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awready,
  input logic              wvalid,
  input logic              wready,
  input logic              wlast,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic              mem_we,
  input logic [OFF_W-1:0]  mem_lane,
  input logic [STRB_W-1:0] mem_be,
  input logic              viol_pulse
);

  p_aw_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !awready);

  p_w_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && wready && wlast) |=> !wready);

  p_lane_from_strb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be[mem_lane] &&
                ((mem_be & ((STRB_W'(1) << mem_lane) - STRB_W'(1))) == '0)));

  p_empty_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be != '0));

  p_viol_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> !mem_we);

  p_resp_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp == 2'b00 || bresp == 2'b10));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |=> !viol_pulse);

  p_b_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bresp)));

endmodule

bind wstrb_guard wsg_guard_sva #(.STRB_W(STRB_W), .OFF_W(OFF_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .awready    (s_awready),
  .wvalid     (s_wvalid),
  .wready     (s_wready),
  .wlast      (s_wlast),
  .bvalid     (s_bvalid),
  .bready     (s_bready),
  .bresp      (s_bresp),
  .mem_we     (mem_we),
  .mem_lane   (mem_addr[OFF_W-1:0]),
  .mem_be     (mem_be),
  .viol_pulse (viol_pulse)
);

// File: tb/tb_wstrb_guard.sv
module tb_wstrb_guard;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              s_awvalid = 1'b0;
  logic              s_awready;
  logic [ADDR_W-1:0] s_awaddr = '0;
  logic [2:0]        s_awsize = '0;
  logic              s_wvalid = 1'b0;
  logic              s_wready;
  logic [DATA_W-1:0] s_wdata = '0;
  logic [STRB_W-1:0] s_wstrb = '0;
  logic              s_wlast = 1'b0;
  logic              s_bvalid;
  logic              s_bready = 1'b0;
  logic [1:0]        s_bresp;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [STRB_W-1:0] mem_be;
  logic [DATA_W-1:0] mem_wdata;
  logic              viol_pulse;
  logic [ADDR_W-1:0] viol_addr;

  int checks = 0;
  int errors = 0;

  wstrb_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awsize(s_awsize),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_wlast(s_wlast), .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .viol_pulse(viol_pulse), .viol_addr(viol_addr)
  );

  always #4 clk = ~clk;

  task automatic expect_eq(input string tag, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // address handshake; starts and ends on a falling edge
  task automatic send_aw(input logic [ADDR_W-1:0] addr, input logic [2:0] size);
    s_awaddr  = addr;
    s_awsize  = size;
    s_awvalid = 1'b1;
    expect_eq("R1", "awready idle", s_awready, 1);
    @(posedge clk);
    @(negedge clk);
    s_awvalid = 1'b0;
    expect_eq("R1", "awready after AW", s_awready, 0);
    expect_eq("R2", "wready open", s_wready, 1);
  endtask

  // one data beat and its registered results
  task automatic send_beat(input string tag, input logic [DATA_W-1:0] data,
                           input logic [STRB_W-1:0] strb, input logic last,
                           input logic exp_we, input logic [ADDR_W-1:0] exp_addr,
                           input logic exp_pulse, input logic [ADDR_W-1:0] exp_paddr);
    s_wdata  = data;
    s_wstrb  = strb;
    s_wlast  = last;
    s_wvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_wvalid = 1'b0;
    s_wlast  = 1'b0;
    expect_eq(tag, "mem_we", mem_we, exp_we);
    if (exp_we) begin
      expect_eq(tag, "mem_addr", mem_addr, exp_addr);
      expect_eq(tag, "mem_be", mem_be, strb);
      expect_eq(tag, "mem_wdata", mem_wdata, data);
    end
    expect_eq(tag, "viol_pulse", viol_pulse, exp_pulse);
    if (exp_pulse) expect_eq(tag, "viol_addr", viol_addr, exp_paddr);
    if (last) expect_eq("R2", "wready after last", s_wready, 0);
  endtask

  // response: held under back-pressure, AW refused, then taken
  task automatic finish_b(input string tag, input logic [1:0] exp_resp);
    expect_eq("R9", "bvalid after last", s_bvalid, 1);
    expect_eq(tag, "bresp", s_bresp, exp_resp);
    s_awvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_awvalid = 1'b0;
    expect_eq("R9", "bvalid held", s_bvalid, 1);
    expect_eq("R9", "bresp held", s_bresp, exp_resp);
    expect_eq("R1", "awready during B", s_awready, 0);
    s_bready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_bready = 1'b0;
    expect_eq("R9", "bvalid after B", s_bvalid, 0);
    expect_eq("R1", "awready after B", s_awready, 1);
    expect_eq("R2", "wready idle", s_wready, 0);
  endtask

  task automatic t_reset();
    expect_eq("R11", "awready", s_awready, 1);
    expect_eq("R11", "wready", s_wready, 0);
    expect_eq("R11", "bvalid", s_bvalid, 0);
    expect_eq("R11", "mem_we", mem_we, 0);
    expect_eq("R11", "viol_pulse", viol_pulse, 0);
  endtask

  task automatic t_aligned_late_start();
    send_aw(32'h100, 3'd2);
    send_beat("R4 aligned later start", 32'hA1B2C3D4, 4'b1100, 1'b1, 1'b1, 32'h102, 1'b0, '0);
    finish_b("R7 okay", 2'b00);
  endtask

  task automatic t_unaligned_match();
    send_aw(32'h101, 3'd2);
    send_beat("R4 unaligned match", 32'h11223344, 4'b1110, 1'b1, 1'b1, 32'h101, 1'b0, '0);
    finish_b("R7 okay", 2'b00);
    send_aw(32'h102, 3'd2);
    send_beat("R3 start from strobe", 32'h55667788, 4'b1000, 1'b1, 1'b1, 32'h103, 1'b0, '0);
    finish_b("R7 okay", 2'b00);
  endtask

  task automatic t_unaligned_mismatch();
    send_aw(32'h102, 3'd2);
    send_beat("R4 below offset", 32'hDEADBEEF, 4'b1111, 1'b1, 1'b0, '0, 1'b1, 32'h102);
    finish_b("R7 slverr", 2'b10);
  endtask

  task automatic t_incr_burst();
    send_aw(32'h201, 3'd2);
    send_beat("R3 beat0", 32'h01010101, 4'b1110, 1'b0, 1'b1, 32'h201, 1'b0, '0);
    send_beat("R5 beat1", 32'h02020202, 4'b1111, 1'b0, 1'b1, 32'h204, 1'b0, '0);
    send_beat("R5 beat2", 32'h03030303, 4'b0011, 1'b1, 1'b1, 32'h208, 1'b0, '0);
    finish_b("R7 okay", 2'b00);
  endtask

  task automatic t_narrow_late_viol();
    send_aw(32'h302, 3'd1);
    send_beat("R4 narrow beat0", 32'hAAAA0000, 4'b1100, 1'b0, 1'b1, 32'h302, 1'b0, '0);
    send_beat("R5 narrow beat1", 32'h0000BB00, 4'b0010, 1'b0, 1'b1, 32'h305, 1'b0, '0);
    send_beat("R5 outside window", 32'h000000CC, 4'b0001, 1'b0, 1'b0, '0, 1'b1, 32'h306);
    send_beat("R7 suppressed after", 32'h000000DD, 4'b0001, 1'b1, 1'b0, '0, 1'b0, '0);
    finish_b("R7 slverr", 2'b10);
  endtask

  task automatic t_first_viol_burst();
    send_aw(32'h400, 3'd0);
    send_beat("R4 above window", 32'h00001100, 4'b0010, 1'b0, 1'b0, '0, 1'b1, 32'h400);
    send_beat("R8 no second pulse", 32'h00002200, 4'b0010, 1'b1, 1'b0, '0, 1'b0, '0);
    finish_b("R7 slverr", 2'b10);
  endtask

  task automatic t_empty_strobe();
    send_aw(32'h500, 3'd2);
    send_beat("R6 empty", 32'hFFFFFFFF, 4'b0000, 1'b0, 1'b0, '0, 1'b0, '0);
    send_beat("R6 after empty", 32'h0000005A, 4'b0001, 1'b1, 1'b1, 32'h504, 1'b0, '0);
    finish_b("R6 okay", 2'b00);
  endtask

  task automatic t_oversize();
    send_aw(32'h600, 3'd3);
    send_beat("R10 oversize", 32'h12345678, 4'b1111, 1'b1, 1'b0, '0, 1'b1, 32'h600);
    finish_b("R10 slverr", 2'b10);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_aligned_late_start();
    t_unaligned_match();
    t_unaligned_mismatch();
    t_incr_burst();
    t_narrow_late_viol();
    t_first_viol_burst();
    t_empty_strobe();
    t_oversize();
    repeat (2) @(negedge clk);
    report();
    $finish;
  end

endmodule